// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller that serves up to six banks of 32 pins. Each bank has an output latch, a direction register, a synchronised view of its pin levels, separate enables for rising and falling edge capture, a sticky edge-status register and a per-pin mask. Software reaches every register through a simple synchronous bus. Each write takes one cycle. A read returns its data on the cycle after the read strobe.

Register types are interleaved across banks. Each type has its own base offset: level 0x00, direction 0x0C, set 0x18, clear 0x24, rise enable 0x30, fall enable 0x3C, status 0x48 and mask 0x9C. Banks 0 to 2 sit at that base plus 4 times the bank number. Banks 3 to 5 repeat the same layout in a second window starting at 0x100. The set and clear ports change only the latch bits written as 1. This lets software change single pins without a read-modify-write.

Pin inputs pass through a two-flop synchroniser. Edges are taken between consecutive synchronised samples. A single interrupt line is the OR of every status bit whose mask bit is 1, across all banks.

Top module: `gpio_multibank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every latch, direction, enable, status and mask bit is 0. As a result, pin_out, pin_oe and irq are all 0.
- R2: Address decode works as follows. Register type t (level 0, direction 1, set 2, clear 3, rise enable 4, fall enable 5, status 6) is at byte address 12·t + 4·(b mod 3), plus 0x100 when bank b is 3 or higher. The mask register of bank b is at 0x9C + 4·(b mod 3), plus the same window offset. Bank b owns pin_in, pin_out and pin_oe bits [32·b+31 : 32·b].
- R3: Writing the set register forces to 1 every latch bit written as 1. Latch bits written as 0 keep their value. Reads of the set register return 0.
- R4: Writing the clear register forces to 0 every latch bit written as 1. Latch bits written as 0 keep their value. Reads of the clear register return 0.
- R5: A direction bit of 1 drives the matching pin_oe bit high, which makes the pin an output. A direction bit of 0 makes it an input. The direction register reads back as written. pin_out and pin_oe change only on a write.
- R6: The level register returns pin_in through a two-flop synchroniser. A read whose strobe is sampled at the first clock edge after pin_in changes still returns the old value.
- R7: A rising transition of a synchronised pin sets its status bit when the rise enable bit and the mask bit are both 1.
- R8: A falling transition sets its status bit when the fall enable bit and the mask bit are both 1. With both enables set, either transition sets the bit. With the mask bit at 0, no edge sets it.
- R9: Writing 1 to a status bit clears it. Status bits written as 0 are unchanged. Writing all ones clears the whole bank.
- R10: If an edge is captured in the same cycle that its status bit is written with 1, the bit stays set.
- R11: irq is the OR of (status AND mask) over all banks. Clearing a mask bit drops the interrupt contribution of that bit, even while its status bit stays set.
- R12: A read of an address that decodes to no register returns 0. A write to such an address changes no register. Addresses that are not word aligned, offsets between 0x54 and 0x9B, and upper address bits above bit 8 all count as undecoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| we | input | 1 | Write strobe |
| wdata | input | BANK_W | Write data |
| re | input | 1 | Read strobe |
| rdata | output | BANK_W | Read data, valid the cycle after re |
| pin_in | input | NUM_BANKS·BANK_W | Pad input levels |
| pin_out | output | NUM_BANKS·BANK_W | Output latch values |
| pin_oe | output | NUM_BANKS·BANK_W | Output enables from the direction registers |
| irq | output | 1 | Combined interrupt |

## Verification
The bound checker watches the following on every cycle, through bank 0's addresses:
- outputs are zero after reset;
- a set write leaves the written bits high, and a clear write leaves them low;
- pin_out and pin_oe hold their values when no write occurs;
- irq never falls without a bus write;
- reads of the set register return zero.

Some behaviours need timed stimulus, so only the bench scenarios can show them: the two-cycle synchroniser latency, edge capture under each enable and mask combination, the same-cycle race between an edge and a clear, the second address window, and undecoded addresses.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int MAX_BANKS  = 6;
    localparam int BANK_IDX_W = 3;

    typedef enum logic [2:0] {
        REG_LEVEL = 3'd0,
        REG_DIR   = 3'd1,
        REG_SET   = 3'd2,
        REG_CLR   = 3'd3,
        REG_RISE  = 3'd4,
        REG_FALL  = 3'd5,
        REG_STAT  = 3'd6,
        REG_MASK  = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic                  hit;
        reg_kind_e             kind;
        logic [BANK_IDX_W-1:0] bank;
    } reg_sel_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 6,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam logic [5:0] TYPE_WORDS = 6'd21;
    localparam logic [5:0] MASK_WORD  = 6'd39;

    logic       window;
    logic [5:0] word;
    logic [5:0] quot;
    logic [5:0] rem;
    logic [1:0] slot;
    logic       known;
    reg_kind_e  kind;
    logic [BANK_IDX_W-1:0] bank;

    assign window = addr[8];
    assign word   = addr[7:2];

    always_comb begin
        quot  = word / 6'd3;
        rem   = word - quot * 6'd3;
        known = 1'b0;
        kind  = REG_LEVEL;
        slot  = 2'd0;
        if (word < TYPE_WORDS) begin
            known = 1'b1;
            kind  = reg_kind_e'(quot[2:0]);
            slot  = rem[1:0];
        end else if (word >= MASK_WORD && word < MASK_WORD + 6'd3) begin
            known = 1'b1;
            kind  = REG_MASK;
            slot  = 2'(word - MASK_WORD);
        end
        bank = {1'b0, slot} + (window ? 3'd3 : 3'd0);
    end

    always_comb begin
        sel.kind = kind;
        sel.bank = bank;
        sel.hit  = known && (addr[1:0] == 2'b00)
                && (addr[ADDR_W-1:9] == '0)
                && (int'(bank) < NUM_BANKS);
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
            q_prev <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
            q_prev <= q;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_kind_e         kind,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] pin_in,
    output logic [BANK_W-1:0] latch,
    output logic [BANK_W-1:0] dir,
    output logic [BANK_W-1:0] level,
    output logic [BANK_W-1:0] rise_en,
    output logic [BANK_W-1:0] fall_en,
    output logic [BANK_W-1:0] status,
    output logic [BANK_W-1:0] mask
);
    logic [BANK_W-1:0] prev;
    logic [BANK_W-1:0] captured;
    logic [BANK_W-1:0] w1c;

    gpio_sync #(.W(BANK_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q      (level),
        .q_prev (prev)
    );

    always_comb begin
        captured = ((level & ~prev & rise_en) | (~level & prev & fall_en)) & mask;
        w1c      = (wr && kind == REG_STAT) ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch   <= '0;
            dir     <= '0;
            rise_en <= '0;
            fall_en <= '0;
            mask    <= '0;
        end else if (wr) begin
            unique case (kind)
                REG_SET:  latch   <= latch | wdata;
                REG_CLR:  latch   <= latch & ~wdata;
                REG_DIR:  dir     <= wdata;
                REG_RISE: rise_en <= wdata;
                REG_FALL: fall_en <= wdata;
                REG_MASK: mask    <= wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~w1c) | captured;
    end
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 6,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        we,
    input  logic [BANK_W-1:0]           wdata,
    input  logic                        re,
    output logic [BANK_W-1:0]           rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    output logic                        irq
);
    reg_sel_t sel;

    logic [BANK_W-1:0] lvl_a  [NUM_BANKS];
    logic [BANK_W-1:0] dir_a  [NUM_BANKS];
    logic [BANK_W-1:0] rise_a [NUM_BANKS];
    logic [BANK_W-1:0] fall_a [NUM_BANKS];
    logic [BANK_W-1:0] stat_a [NUM_BANKS];
    logic [BANK_W-1:0] mask_a [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;
    logic [BANK_W-1:0] rd_word;

    gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = we && sel.hit && (int'(sel.bank) == b);

        gpio_bank #(.BANK_W(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (bank_wr),
            .kind    (sel.kind),
            .wdata   (wdata),
            .pin_in  (pin_in[b*BANK_W +: BANK_W]),
            .latch   (pin_out[b*BANK_W +: BANK_W]),
            .dir     (dir_a[b]),
            .level   (lvl_a[b]),
            .rise_en (rise_a[b]),
            .fall_en (fall_a[b]),
            .status  (stat_a[b]),
            .mask    (mask_a[b])
        );

        assign pin_oe[b*BANK_W +: BANK_W] = dir_a[b];
        assign bank_irq[b] = |(stat_a[b] & mask_a[b]);
    end

    assign irq = |bank_irq;

    always_comb begin
        rd_word = '0;
        if (sel.hit) begin
            unique case (sel.kind)
                REG_LEVEL: rd_word = lvl_a[sel.bank];
                REG_DIR:   rd_word = dir_a[sel.bank];
                REG_RISE:  rd_word = rise_a[sel.bank];
                REG_FALL:  rd_word = fall_a[sel.bank];
                REG_STAT:  rd_word = stat_a[sel.bank];
                REG_MASK:  rd_word = mask_a[sel.bank];
                default:   rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= rd_word;
    end
endmodule

// File: rtl/gpio_multibank_chk.sv
module gpio_multibank_chk #(
    parameter int NUM_BANKS = 6,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           addr,
    input logic                        we,
    input logic [BANK_W-1:0]           wdata,
    input logic                        re,
    input logic [BANK_W-1:0]           rdata,
    input logic [NUM_BANKS*BANK_W-1:0] pin_out,
    input logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    input logic                        irq
);
    localparam logic [ADDR_W-1:0] SET0 = ADDR_W'(12'h018);
    localparam logic [ADDR_W-1:0] CLR0 = ADDR_W'(12'h024);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0 && !irq));

    // R3
    set_forces_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SET0) |=>
            ((pin_out[BANK_W-1:0] & $past(wdata)) == $past(wdata)));

    // R4
    clear_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == CLR0) |=> ((pin_out[BANK_W-1:0] & $past(wdata)) == '0));

    // R5
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(pin_out) && $stable(pin_oe)));

    // R11
    irq_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq) && $past(rst_n)) |-> $past(we));

    // R3
    set_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && addr == SET0) |=> (rdata == '0));
endmodule

bind gpio_multibank gpio_multibank_chk #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .we      (we),
    .wdata   (wdata),
    .re      (re),
    .rdata   (rdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/tb_gpio_multibank.sv
`timescale 1ns/1ps
module tb_gpio_multibank;
    localparam int NB = 6;
    localparam int W  = 32;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic              we = 1'b0;
    logic [W-1:0]      wdata = '0;
    logic              re = 1'b0;
    logic [W-1:0]      rdata;
    logic [NB*W-1:0]   pin_in = '0;
    logic [NB*W-1:0]   pin_out;
    logic [NB*W-1:0]   pin_oe;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    gpio_multibank #(.NUM_BANKS(NB), .BANK_W(W), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .re(re), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    // kind: 0 level .. 6 status, 7 mask
    function automatic logic [AW-1:0] ra(input int kind, input int bank);
        int base;
        base = (kind == 7) ? 'h9C : kind * 'h0C;
        return AW'(((bank >= 3) ? 'h100 : 0) + base + 4 * (bank % 3));
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
        @(negedge clk); addr = a; re = 1'b1;
        @(negedge clk); re = 1'b0; d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [W-1:0] d;
        chk("R1 pin_out", W'(|pin_out), '0);
        chk("R1 pin_oe", W'(|pin_oe), '0);
        chk("R1 irq", W'(irq), '0);
        rd(ra(6, 0), d); chk("R1 status", d, '0);
    endtask

    task automatic t_setclr;
        logic [W-1:0] d;
        wr(ra(2, 0), 32'h0000_00F0);
        wr(ra(2, 0), 32'h0000_0003);
        chk("R3 set accumulates", pin_out[W-1:0], 32'h0000_00F3);
        wr(ra(3, 0), 32'h0000_0030);
        chk("R4 clear selective", pin_out[W-1:0], 32'h0000_00C3);
        rd(ra(2, 0), d); chk("R3 set reads zero", d, '0);
        rd(ra(3, 0), d); chk("R4 clear reads zero", d, '0);
    endtask

    task automatic t_dir;
        logic [W-1:0] d;
        wr(ra(1, 2), 32'hA5A5_0001);
        chk("R5 pin_oe bank2", pin_oe[2*W +: W], 32'hA5A5_0001);
        rd(ra(1, 2), d); chk("R5 dir readback", d, 32'hA5A5_0001);
        chk("R5 other banks oe", W'(|pin_oe[W +: W]), '0);
    endtask

    task automatic t_level;
        logic [W-1:0] d;
        pin_in[W +: W] = 32'h1234_5678;
        idle(3);
        @(negedge clk); pin_in[W +: W] = 32'hCAFE_0000; addr = ra(0, 1); re = 1'b1;
        @(negedge clk); re = 1'b0; d = rdata;
        chk("R6 synchroniser latency", d, 32'h1234_5678);
        idle(2);
        rd(ra(0, 1), d); chk("R6 level new", d, 32'hCAFE_0000);
    endtask

    task automatic t_edges;
        logic [W-1:0] d;
        wr(ra(4, 0), 32'h0000_0005);
        wr(ra(5, 0), 32'h0000_0006);
        wr(ra(7, 0), 32'h0000_0003);
        @(negedge clk); pin_in[3:0] = 4'hF; idle(4);
        rd(ra(6, 0), d); chk("R7 rise captured only where enabled+masked", d, 32'h1);
        chk("R11 irq on status", W'(irq), 32'h1);
        wr(ra(6, 0), 32'hFFFF_FFFF);
        rd(ra(6, 0), d); chk("R9 clear all", d, '0);
        @(negedge clk); pin_in[3:0] = 4'h0; idle(4);
        rd(ra(6, 0), d); chk("R8 fall captured where enabled+masked", d, 32'h2);
        wr(ra(6, 0), 32'h0000_0001);
        rd(ra(6, 0), d); chk("R9 zero bits untouched", d, 32'h2);
        wr(ra(6, 0), 32'h0000_0002);
    endtask

    task automatic t_collision;
        logic [W-1:0] d;
        wr(ra(4, 1), 32'h0000_0100);
        wr(ra(5, 1), 32'h0000_0100);
        wr(ra(7, 1), 32'h0000_0100);
        @(negedge clk); pin_in[W+8] = 1'b1; idle(4);
        rd(ra(6, 1), d); chk("R8 both enables rise", d, 32'h100);
        @(negedge clk); pin_in[W+8] = 1'b0;
        @(negedge clk);
        wr(ra(6, 1), 32'h0000_0100);
        rd(ra(6, 1), d); chk("R10 edge wins over clear", d, 32'h100);
        wr(ra(6, 1), 32'h0000_0100);
        rd(ra(6, 1), d); chk("R9 later clear", d, '0);
    endtask

    task automatic t_mask_irq;
        logic [W-1:0] d;
        wr(ra(4, 5), 32'h8000_0000);
        wr(ra(7, 5), 32'h8000_0000);
        @(negedge clk); pin_in[5*W+31] = 1'b1; idle(4);
        chk("R11 irq from bank5", W'(irq), 32'h1);
        wr(ra(7, 5), 32'h0);
        chk("R11 mask drops irq", W'(irq), 32'h0);
        rd(ra(6, 5), d); chk("R11 status kept", d, 32'h8000_0000);
        @(negedge clk); pin_in[5*W+31] = 1'b0; idle(1);
        @(negedge clk); pin_in[5*W+31] = 1'b1; idle(4);
        wr(ra(6, 5), 32'hFFFF_FFFF);
        rd(ra(6, 5), d); chk("R8 masked pin no capture", d, '0);
    endtask

    task automatic t_window;
        wr(AW'(12'h11C), 32'h0F0F_0000);
        chk("R2 set bank4 at 0x11C", pin_out[4*W +: W], 32'h0F0F_0000);
        wr(AW'(12'h114), 32'h0000_00FF);
        chk("R2 dir bank5 at 0x114", pin_oe[5*W +: W], 32'h0000_00FF);
        chk("R2 bank3 untouched", pin_out[3*W +: W], '0);
    endtask

    task automatic t_unmapped;
        logic [W-1:0] d;
        logic [NB*W-1:0] before_o, before_e;
        before_o = pin_out; before_e = pin_oe;
        wr(AW'(12'h060), 32'hFFFF_FFFF);
        wr(AW'(12'h01A), 32'hFFFF_FFFF);
        wr(AW'(12'h818), 32'hFFFF_FFFF);
        chk("R12 writes ignored out", W'(pin_out != before_o), '0);
        chk("R12 writes ignored oe", W'(pin_oe != before_e), '0);
        rd(AW'(12'h060), d); chk("R12 read zero", d, '0);
        rd(AW'(12'h80C), d); chk("R12 high bits read zero", d, '0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset;
        t_setclr;
        t_dir;
        t_level;
        t_edges;
        t_collision;
        t_mask_irq;
        t_window;
        t_unmapped;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule